// File: doc/BRIEF.md
# Dithered Phase Generator for a Numerically Controlled Oscillator

This block produces the phase word that addresses a downstream sine/cosine table. A signed accumulator of `ACC_W` bits, with no fraction bits, adds the phase increment on every cycle in which `valid_in` is high. It keeps its value when `valid_in` is low and wraps on overflow. The accumulator value then passes through two pipeline stages. The first stage adds a phase offset and a small dither term. The second stage keeps the top `Q_W` bits, which floors the sum. Those top bits appear on `phase_q` as a two's-complement word.

A three-stage flag, `phase_vld`, marks which `phase_q` words come from accepted samples. A six-stage flag, `valid_out`, gives the table stage a valid signal aligned to a fixed total latency of six cycles. The dither source is chosen at build time by `DITH_MODE`:
- none;
- a free-running LFSR whose low bits are used;
- the `dither_in` port.

Flow control is valid-only. The downstream table must take every word, because the phase path can neither stall nor drop a sample, so there is no ready signal. A sample that is not accepted simply does not advance the accumulator.

Top module: `nco_phase_front`

## Requirements
- R1: When `valid_in` is high and `rst` is low at a clock edge, the accumulator becomes the old accumulator plus `phase_inc`, modulo 2^ACC_W.
- R2: When `valid_in` is low and `rst` is low, the accumulator keeps its value exactly.
- R3: `rst` is synchronous. At an edge where it is high, the accumulator, both pipeline stages and every valid-flag stage are cleared, whatever `valid_in` is. After that edge `phase_q`, `phase_vld` and `valid_out` read 0.
- R4: The first pipeline stage registers S = acc + `phase_ofs` + zero-extended dither, modulo 2^ACC_W. One edge later, `phase_q` = S[ACC_W-1 : ACC_W-Q_W] (floor division by 2^(ACC_W-Q_W)). For `valid_in` sampled at edge k, the matching `phase_q` appears after edge k+2.
- R5: The offset is applied after the accumulator register. Applying any `phase_ofs` and then returning it to zero leaves the accumulator, and so `phase_q`, as it would have been without the offset.
- R6: With `DITH_MODE` = DITH_PORT, the `DITH_W`-bit `dither_in` value is zero-extended and added at the LSB end of S, in the same cycle as `phase_ofs`.
- R7: With `DITH_MODE` = DITH_LFSR, the dither is the low `DITH_W` bits of a 16-bit Fibonacci LFSR (taps 16, 14, 13, 11; nonzero seed) that steps every cycle. The dither is at most 2^DITH_W-1, where `DITH_W` <= ACC_W-Q_W, so `phase_q` equals the undithered floor value or that value plus one (modulo 2^Q_W).
- R8: `phase_vld` is `valid_in` delayed by 3 edges, and `valid_out` is `valid_in` delayed by 6 edges.
- R9: With `DITH_MODE` = DITH_NONE, no dither is added and `phase_ofs` is the only term added to the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Accepts `phase_inc` this cycle and advances the accumulator |
| phase_inc | input | ACC_W | Phase increment, two's complement |
| phase_ofs | input | ACC_W | Phase offset, two's complement, applied after the accumulator |
| dither_in | input | DITH_W | External dither, used only when `DITH_MODE` is DITH_PORT |
| phase_q | output | Q_W | Quantized phase, two's complement, zero fraction bits |
| phase_vld | output | 1 | Marks `phase_q` words that come from accepted samples |
| valid_out | output | 1 | Valid flag aligned to the six-cycle table output |

## Verification
The accumulator changes one edge after an accepted sample. The sum stage captures the offset and dither in the following cycle, so `phase_q` reflects them two edges after they are driven. `phase_vld` rises three edges after `valid_in`, and `valid_out` rises six edges after it. The bench drives its inputs on the falling edge and keeps a shift register of expected values. It compares `phase_q` against the entry computed two iterations earlier. It compares the two flags against the `valid_in` history three and six iterations back. The directed tests wait out the full pipeline before sampling.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef enum logic [1:0] {
    DITH_NONE = 2'd0,
    DITH_LFSR = 2'd1,
    DITH_PORT = 2'd2
  } dith_mode_e;

  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [ACC_W-1:0] inc,
  output logic [ACC_W-1:0] acc
);
  logic [ACC_W-1:0] acc_r;

  // wraps modulo 2^ACC_W; no saturation
  always_ff @(posedge clk) begin
    if (rst)      acc_r <= '0;
    else if (adv) acc_r <= acc_r + inc;
  end

  assign acc = acc_r;
endmodule

// File: rtl/nco_dither_src.sv
module nco_dither_src #(
  parameter int                 DITH_W    = 4,
  parameter nco_pkg::dith_mode_e DITH_MODE = nco_pkg::DITH_LFSR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DITH_W-1:0] dither_in,
  output logic [DITH_W-1:0] dith
);
  localparam int LW = nco_pkg::LFSR_W;

  generate
    if (DITH_MODE == nco_pkg::DITH_PORT) begin : g_port
      assign dith = dither_in;
    end else if (DITH_MODE == nco_pkg::DITH_LFSR) begin : g_lfsr
      logic [LW-1:0] lfsr;
      logic          fb;
      wire           unused_dither_in = ^dither_in;
      assign fb = lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10];
      always_ff @(posedge clk) begin
        if (rst) lfsr <= nco_pkg::LFSR_SEED;
        else     lfsr <= {lfsr[LW-2:0], fb};
      end
      assign dith = lfsr[DITH_W-1:0];
    end else begin : g_none
      wire unused_dither_in = ^dither_in;
      wire unused_clk_rst   = clk ^ rst;
      assign dith = '0;
    end
  endgenerate
endmodule

// File: rtl/nco_phase_quant.sv
module nco_phase_quant #(
  parameter int ACC_W  = 16,
  parameter int Q_W    = 12,
  parameter int DITH_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ACC_W-1:0]  acc,
  input  logic [ACC_W-1:0]  ofs,
  input  logic [DITH_W-1:0] dith,
  output logic [Q_W-1:0]    phase_q
);
  localparam int SHIFT = ACC_W - Q_W;

  logic [ACC_W-1:0] dith_ext;
  logic [ACC_W-1:0] sum_c;
  logic [ACC_W-1:0] sum_r;
  logic [Q_W-1:0]   q_r;

  assign dith_ext = {{(ACC_W-DITH_W){1'b0}}, dith};
  assign sum_c    = acc + ofs + dith_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_r <= '0;
      q_r   <= '0;
    end else begin
      sum_r <= sum_c;
      q_r   <= sum_r[ACC_W-1:SHIFT];  // floor: drop LSBs
    end
  end

  wire unused_lsb = ^sum_r[SHIFT-1:0];
  assign phase_q = q_r;
endmodule

// File: rtl/nco_valid_delay.sv
module nco_valid_delay #(
  parameter int DEPTH = 6,
  parameter int TAP   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic tap_out,
  output logic last_out
);
  logic [DEPTH-1:0] sr;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      logic d;
      if (i == 0) begin : g_first
        assign d = din;
      end else begin : g_next
        assign d = sr[i-1];
      end
      always_ff @(posedge clk) begin
        if (rst) sr[i] <= 1'b0;
        else     sr[i] <= d;
      end
    end
  endgenerate

  assign tap_out  = sr[TAP-1];
  assign last_out = sr[DEPTH-1];
endmodule

// File: rtl/nco_phase_front.sv
module nco_phase_front #(
  parameter int                  ACC_W     = 16,
  parameter int                  Q_W       = 12,
  parameter int                  DITH_W    = 4,
  parameter nco_pkg::dith_mode_e DITH_MODE = nco_pkg::DITH_LFSR
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_in,
  input  logic [ACC_W-1:0]  phase_inc,
  input  logic [ACC_W-1:0]  phase_ofs,
  input  logic [DITH_W-1:0] dither_in,
  output logic [Q_W-1:0]    phase_q,
  output logic              phase_vld,
  output logic              valid_out
);
  localparam int PH_LAT  = 3;
  localparam int OUT_LAT = 6;

  logic [ACC_W-1:0]  acc_w;
  logic [DITH_W-1:0] dith_w;

  nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .adv(valid_in), .inc(phase_inc), .acc(acc_w)
  );

  nco_dither_src #(.DITH_W(DITH_W), .DITH_MODE(DITH_MODE)) u_dith (
    .clk(clk), .rst(rst), .dither_in(dither_in), .dith(dith_w)
  );

  nco_phase_quant #(.ACC_W(ACC_W), .Q_W(Q_W), .DITH_W(DITH_W)) u_quant (
    .clk(clk), .rst(rst), .acc(acc_w), .ofs(phase_ofs), .dith(dith_w),
    .phase_q(phase_q)
  );

  nco_valid_delay #(.DEPTH(OUT_LAT), .TAP(PH_LAT)) u_vdly (
    .clk(clk), .rst(rst), .din(valid_in), .tap_out(phase_vld),
    .last_out(valid_out)
  );
endmodule

// File: rtl/nco_phase_front_chk.sv
module nco_phase_front_chk #(
  parameter int ACC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             valid_in,
  input logic [ACC_W-1:0] phase_inc,
  input logic [ACC_W-1:0] acc,
  input logic             phase_vld,
  input logic             valid_out
);
  logic [2:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= '0;
    else if (since_rst != 7) since_rst <= since_rst + 3'd1;
  end

  a_r1_advance: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> acc == ACC_W'($past(acc) + $past(phase_inc)));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> $stable(acc));

  a_r3_cleared: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (acc == '0 && !phase_vld && !valid_out));

  a_r8_phase_vld: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd3) |-> phase_vld == $past(valid_in, 3));

  a_r8_valid_out: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd6) |-> valid_out == $past(valid_in, 6));
endmodule

bind nco_phase_front nco_phase_front_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .valid_in(valid_in), .phase_inc(phase_inc),
  .acc(acc_w), .phase_vld(phase_vld), .valid_out(valid_out)
);

// File: tb/sim_nco_phase_front.sv
`timescale 1ns/1ps
module sim_nco_phase_front;
  typedef struct packed {
    logic        v;
    logic [15:0] inc;
    logic [15:0] ofs;
    logic [3:0]  dith;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'd100,   16'h0000, 4'd0},
    '{1'b1, 16'd100,   16'h0000, 4'd0},
    '{1'b1, 16'd100,   16'h0000, 4'd15},
    '{1'b0, 16'd999,   16'h0000, 4'd0},
    '{1'b0, 16'd999,   16'h0000, 4'd0},
    '{1'b1, 16'd100,   16'h0100, 4'd3},
    '{1'b1, 16'h7FFF,  16'h0000, 4'd0},
    '{1'b1, 16'h7FFF,  16'h0000, 4'd8},
    '{1'b1, 16'hFF00,  16'h0000, 4'd0},
    '{1'b0, 16'h1234,  16'h8000, 4'd15},
    '{1'b1, 16'h0001,  16'hFFFF, 4'd0},
    '{1'b1, 16'h0001,  16'h0000, 4'd15},
    '{1'b1, 16'h4000,  16'h0000, 4'd1},
    '{1'b1, 16'h4000,  16'h0000, 4'd0},
    '{1'b0, 16'h0000,  16'h0000, 4'd0},
    '{1'b1, 16'h8000,  16'h0010, 4'd7},
    '{1'b0, 16'h0000,  16'h0000, 4'd0},
    '{1'b0, 16'h0000,  16'h0000, 4'd0},
    '{1'b0, 16'h0000,  16'h0000, 4'd0},
    '{1'b0, 16'h0000,  16'h0000, 4'd0},
    '{1'b0, 16'h0000,  16'h0000, 4'd0},
    '{1'b0, 16'h0000,  16'h0000, 4'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_in = 1'b0;
  logic [15:0] phase_inc = '0;
  logic [15:0] phase_ofs = '0;
  logic [3:0]  dither_in = '0;
  logic [11:0] q0, q1, q2;
  logic        pv0, pv1, pv2, vo0, vo1, vo2;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  nco_phase_front #(.DITH_MODE(nco_pkg::DITH_PORT)) u0 (
    .clk(clk), .rst(rst), .valid_in(valid_in), .phase_inc(phase_inc),
    .phase_ofs(phase_ofs), .dither_in(dither_in), .phase_q(q0),
    .phase_vld(pv0), .valid_out(vo0));

  nco_phase_front #(.DITH_MODE(nco_pkg::DITH_LFSR)) u1 (
    .clk(clk), .rst(rst), .valid_in(valid_in), .phase_inc(phase_inc),
    .phase_ofs(phase_ofs), .dither_in(dither_in), .phase_q(q1),
    .phase_vld(pv1), .valid_out(vo1));

  nco_phase_front #(.DITH_MODE(nco_pkg::DITH_NONE)) u2 (
    .clk(clk), .rst(rst), .valid_in(valid_in), .phase_inc(phase_inc),
    .phase_ofs(phase_ofs), .dither_in(dither_in), .phase_q(q2),
    .phase_vld(pv2), .valid_out(vo2));

  function automatic logic [11:0] quant(input logic [15:0] a,
                                        input logic [15:0] o,
                                        input logic [3:0] d);
    logic [15:0] s;
    s = a + o + {12'd0, d};
    return s[15:4];
  endfunction

  task automatic check(input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_lfsr(input logic [11:0] act, input logic [11:0] base);
    logic [11:0] up;
    up = base + 12'd1;
    total++;
    if (act !== base && act !== up) begin
      bad++;
      $display("FAIL R7 actual=%h expected=%h or %h", act, base, up);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  logic [15:0] acc_m;
  logic [11:0] e1, e2, n1, n2;
  logic        vh [NV];

  initial begin
    acc_m = '0;
    e1 = '0; e2 = '0; n1 = '0; n2 = '0;
    repeat (3) @(negedge clk);
    // R3: state after reset
    check("R3 phase_q", {4'd0, q0}, 16'd0);
    check("R3 phase_vld", {15'd0, pv0}, 16'd0);
    check("R3 valid_out", {15'd0, vo0}, 16'd0);
    rst = 1'b0;

    for (int j = 0; j < NV; j++) begin
      // outputs here reflect the edge just passed
      check("R4/R1/R2/R6 phase_q", {4'd0, q0}, {4'd0, e2});
      check("R9 phase_q", {4'd0, q2}, {4'd0, n2});
      check_lfsr(q1, n2);
      check("R8 phase_vld", {15'd0, pv0}, {15'd0, (j >= 3) ? vh[j-3] : 1'b0});
      check("R8 valid_out", {15'd0, vo0}, {15'd0, (j >= 6) ? vh[j-6] : 1'b0});
      valid_in  = VEC[j].v;
      phase_inc = VEC[j].inc;
      phase_ofs = VEC[j].ofs;
      dither_in = VEC[j].dith;
      e2 = e1; e1 = quant(acc_m, VEC[j].ofs, VEC[j].dith);
      n2 = n1; n1 = quant(acc_m, VEC[j].ofs, 4'd0);
      if (VEC[j].v) acc_m = acc_m + VEC[j].inc;
      vh[j] = VEC[j].v;
      @(negedge clk);
    end

    // R5: offset applied then removed leaves the accumulator untouched
    valid_in = 1'b0; dither_in = '0; phase_ofs = 16'h4000;
    repeat (3) @(negedge clk);
    check("R5 offset applied", {4'd0, q0}, {4'd0, quant(acc_m, 16'h4000, 4'd0)});
    phase_ofs = 16'h0000;
    repeat (3) @(negedge clk);
    check("R5 offset removed", {4'd0, q0}, {4'd0, quant(acc_m, 16'h0000, 4'd0)});
    valid_in = 1'b1; phase_inc = 16'h0010;
    @(negedge clk);
    acc_m = acc_m + 16'h0010;
    valid_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R5 advance after offset", {4'd0, q0}, {4'd0, quant(acc_m, 16'h0, 4'd0)});

    // R3: reset wins over valid_in and clears the pipeline
    valid_in = 1'b1; phase_inc = 16'h0123; phase_ofs = 16'h0400; rst = 1'b1;
    @(negedge clk);
    check("R3 phase_q mid-run", {4'd0, q0}, 16'd0);
    check("R3 phase_vld mid-run", {15'd0, pv0}, 16'd0);
    check("R3 valid_out mid-run", {15'd0, vo0}, 16'd0);
    rst = 1'b0; valid_in = 1'b0; phase_ofs = '0;
    repeat (3) @(negedge clk);
    check("R3 accumulator zero", {4'd0, q0}, 16'd0);
    check("R3 valid_out stays low", {15'd0, vo0}, 16'd0);

    // R8: single-cycle pulse timing
    valid_in = 1'b1; phase_inc = 16'h0040;
    for (int n = 1; n <= 8; n++) begin
      @(negedge clk);
      valid_in = 1'b0;
      check("R8 pulse phase_vld", {15'd0, pv0}, {15'd0, n == 3});
      check("R8 pulse valid_out", {15'd0, vo0}, {15'd0, n == 6});
      if (n == 3) check("R4 pulse phase_q", {4'd0, q0}, 16'h0004);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule